// File: doc/BRIEF.md
# SECDED-Corrected Frame Receiver

This block sits on the receive side of a point-to-point link that moves a fixed set of registered signals from one end to the other. Each 128-bit frame carries a 104-bit payload and a 16-bit CRC of that payload. Both are protected by an extended Hamming code, which can correct one bit and detect two. The block decodes the code, repairs a single flipped bit, and checks the CRC over the repaired payload. It then either copies the payload into its output register or rejects the frame.

Frames arrive on a valid/ready stream. `in_ready` is low while reset is asserted and high at every other time. A frame is consumed on each rising edge where `in_valid` and `in_ready` are both high. The sender may present a new frame on every cycle and need not hold a frame after it has been taken. While `in_valid` is low, the value on `in_frame` has no effect.

A rejected frame leaves the payload register unchanged and raises a retransmit-request flag. The local transmitter places that flag in the reverse-direction frame. The flag remains set until a frame is accepted. The far end's own error indicator is one bit of the payload. It is brought out separately, and a saturating counter per outcome records the link quality.

Top module: `secded_frame_rx`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and 1 otherwise. A frame taken at a rising edge affects the outputs at the following rising edge.
- R2: Frame bit p holds code position p. Position 0 is an overall even-parity bit over all 128 bits. Positions 1, 2, 4, …, 64 are Hamming check bits. The remaining positions, in ascending order, carry data bits 0..119. Data[103:0] is the payload and data[119:104] is the CRC. An error-free frame with a matching CRC is accepted and counted in `cnt_clean`.
- R3: A single flipped bit at any position, including position 0, is corrected. If the CRC then matches, the frame is accepted exactly like a clean one and counted in `cnt_fixed`.
- R4: A nonzero syndrome with even overall parity is a double error. The frame is rejected without the CRC result being used, and it is counted in `cnt_dbl`. A syndrome that names a position outside the frame is handled the same way.
- R5: The CRC uses polynomial 0x1021 with initial value 0xFFFF. It is computed MSB-first over payload bit 103 down to bit 0, with no reflection and no final XOR. On a mismatch, including after a correction, the frame is rejected and counted in `cnt_crc`.
- R6: On acceptance, `pay_q` loads the payload and `pay_upd` is high for exactly that one cycle.
- R7: On rejection, `pay_q` holds its value, `pay_upd` stays low and `retx_req` is set. `retx_req` is cleared only by the next acceptance.
- R8: `remote_err` equals payload bit 103 of the most recently accepted frame and is unchanged by rejected frames.
- R9: Each counter stops at 2^CNT_W−1 and never wraps.
- R10: Reset clears `pay_q`, `pay_upd`, `retx_req`, `remote_err` and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame present on `in_frame` |
| in_ready | output | 1 | Block can take a frame |
| in_frame | input | CW_W | Received codeword |
| pay_q | output | PAY_W | Last accepted payload |
| pay_upd | output | 1 | One-cycle strobe when `pay_q` is loaded |
| retx_req | output | 1 | Request to the far end to repeat |
| remote_err | output | 1 | Far end's error indicator from last accepted payload |
| cnt_clean | output | CNT_W | Frames accepted with no error |
| cnt_fixed | output | CNT_W | Frames accepted after a single-bit repair |
| cnt_crc | output | CNT_W | Frames rejected on CRC mismatch |
| cnt_dbl | output | CNT_W | Frames rejected as double errors |

## Verification
Decoding of one frame and committing the previous one take place in the same cycle. A rejection in one cycle can therefore be followed by an acceptance in the very next cycle, with the flag set and cleared on consecutive edges. This is provoked by driving valid on consecutive cycles with clean, single-error, CRC-failing and double-error frames mixed together. A behavioural model that tracks the pending frame compares every output on every clock. Counter saturation falling in the same cycle as an acceptance is exercised by building the bench's instance with 4-bit counters and sending long runs of one outcome.

// File: rtl/secded_rx_pkg.sv
package secded_rx_pkg;

  typedef enum logic [1:0] {
    FR_CLEAN  = 2'd0,
    FR_FIXED  = 2'd1,
    FR_DOUBLE = 2'd2
  } fr_class_e;

  localparam int EV_CLEAN = 0;
  localparam int EV_FIXED = 1;
  localparam int EV_CRC   = 2;
  localparam int EV_DBL   = 3;
  localparam int N_EV     = 4;

endpackage

// File: rtl/secded_decode.sv
module secded_decode
  import secded_rx_pkg::*;
#(
  parameter int CW_W = 128,
  localparam int PB  = $clog2(CW_W),
  localparam int DW  = CW_W - PB - 1
) (
  input  logic [CW_W-1:0] cw_i,
  output logic [DW-1:0]   data_o,
  output fr_class_e       cls_o
);

  logic [PB-1:0]   syn;
  logic            par;
  logic [CW_W-1:0] fix;
  logic [CW_W-1:0] corr;

  // syndrome: XOR of indices of all set bits; overall parity over all bits
  always_comb begin
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw_i[p]) syn = syn ^ PB'(p);
    end
    par = ^cw_i;
  end

  // classification: odd parity means one flip (maybe bit 0 alone)
  always_comb begin
    if (syn == '0 && !par)           cls_o = FR_CLEAN;
    else if (par && int'(syn) < CW_W) cls_o = FR_FIXED;
    else                             cls_o = FR_DOUBLE;
  end

  always_comb begin
    fix = '0;
    if (cls_o == FR_FIXED && syn != '0) fix[syn] = 1'b1;
    corr = cw_i ^ fix;
  end

  // pick data from non-power-of-two positions, ascending
  always_comb begin
    int k;
    k = 0;
    data_o = '0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        data_o[k] = corr[p];
        k++;
      end
    end
  end

endmodule

// File: rtl/crc_calc.sv
module crc_calc #(
  parameter int             DATA_W = 104,
  parameter int             CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = '1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_o = c;
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (inc && !(&q))  q <= q + 1'b1;
  end

  // R9: a full counter stays full
  a_r9_hold_max: assert property (@(posedge clk) disable iff (rst)
    (&q) |=> (&q));

  // R9: an increment moves by one unless already full
  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !(&q)) |=> (q == $past(q) + 1'b1));

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(q));

endmodule

// File: rtl/secded_frame_rx.sv
module secded_frame_rx
  import secded_rx_pkg::*;
#(
  parameter int CW_W     = 128,
  parameter int PAY_W    = 104,
  parameter int CNT_W    = 16,
  parameter int REM_BIT  = PAY_W - 1,
  parameter int CRC_POLY = 'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW_W-1:0]  in_frame,
  output logic [PAY_W-1:0] pay_q,
  output logic             pay_upd,
  output logic             retx_req,
  output logic             remote_err,
  output logic [CNT_W-1:0] cnt_clean,
  output logic [CNT_W-1:0] cnt_fixed,
  output logic [CNT_W-1:0] cnt_crc,
  output logic [CNT_W-1:0] cnt_dbl
);

  localparam int PB    = $clog2(CW_W);
  localparam int DW    = CW_W - PB - 1;
  localparam int CRC_W = DW - PAY_W;

  logic            fire;
  logic [DW-1:0]   dec_data;
  fr_class_e       dec_cls;
  logic            a_vld;
  logic [DW-1:0]   a_data;
  fr_class_e       a_cls;
  logic [CRC_W-1:0] crc_calc_v;
  logic            crc_ok;
  logic [N_EV-1:0] ev;
  logic            acc;
  logic            rej;
  logic [CNT_W-1:0] cnt [N_EV];

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;

  secded_decode #(.CW_W(CW_W)) u_dec (
    .cw_i   (in_frame),
    .data_o (dec_data),
    .cls_o  (dec_cls)
  );

  // stage A: hold decoded frame for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld  <= 1'b0;
      a_data <= '0;
      a_cls  <= FR_CLEAN;
    end else begin
      a_vld <= fire;
      if (fire) begin
        a_data <= dec_data;
        a_cls  <= dec_cls;
      end
    end
  end

  crc_calc #(
    .DATA_W (PAY_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_W'(CRC_POLY)),
    .INIT   ({CRC_W{1'b1}})
  ) u_crc (
    .data_i (a_data[PAY_W-1:0]),
    .crc_o  (crc_calc_v)
  );

  assign crc_ok = (crc_calc_v == a_data[DW-1:PAY_W]);

  // outcome decision: double errors never consult the CRC
  always_comb begin
    ev = '0;
    if (a_vld) begin
      ev[EV_DBL]   = (a_cls == FR_DOUBLE);
      ev[EV_CLEAN] = (a_cls == FR_CLEAN) && crc_ok;
      ev[EV_FIXED] = (a_cls == FR_FIXED) && crc_ok;
      ev[EV_CRC]   = (a_cls != FR_DOUBLE) && !crc_ok;
    end
  end

  assign acc = ev[EV_CLEAN] | ev[EV_FIXED];
  assign rej = ev[EV_CRC]   | ev[EV_DBL];

  // stage B: commit or reject
  always_ff @(posedge clk) begin
    if (rst) begin
      pay_q      <= '0;
      pay_upd    <= 1'b0;
      retx_req   <= 1'b0;
      remote_err <= 1'b0;
    end else begin
      pay_upd <= acc;
      if (acc) begin
        pay_q      <= a_data[PAY_W-1:0];
        remote_err <= a_data[REM_BIT];
        retx_req   <= 1'b0;
      end else if (rej) begin
        retx_req <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_EV; i++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (ev[i]),
      .q   (cnt[i])
    );
  end

  assign cnt_clean = cnt[EV_CLEAN];
  assign cnt_fixed = cnt[EV_FIXED];
  assign cnt_crc   = cnt[EV_CRC];
  assign cnt_dbl   = cnt[EV_DBL];

  // R2/R3/R4/R5: each decoded frame lands in exactly one outcome
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
    a_vld |-> $onehot(ev));

  // R6: payload register moves only with its strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !pay_upd |-> $stable(pay_q));

  // R7: rejection raises the request and suppresses the strobe
  a_r7_set: assert property (@(posedge clk) disable iff (rst)
    rej |=> (retx_req && !pay_upd));

  // R7: an accepted frame always leaves the request low
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    pay_upd |-> !retx_req);

  // R4: a double error never produces an update
  a_r4_no_update: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_cls == FR_DOUBLE) |=> !pay_upd);

  // R8: remote flag follows accepted frames only
  a_r8_remote_hold: assert property (@(posedge clk) disable iff (rst)
    !pay_upd |-> $stable(remote_err));

endmodule

// File: tb/sim_secded_frame_rx.sv
module sim_secded_frame_rx;

  localparam int CN = 4;
  localparam logic [CN-1:0] CMAX = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_frame = '0;
  logic [103:0] pay_q;
  logic         pay_upd, retx_req, remote_err;
  logic [CN-1:0] cnt_clean, cnt_fixed, cnt_crc, cnt_dbl;

  always #5 clk = ~clk;

  secded_frame_rx #(.CNT_W(CN)) u0 (
    .clk, .rst, .in_valid, .in_ready, .in_frame,
    .pay_q, .pay_upd, .retx_req, .remote_err,
    .cnt_clean, .cnt_fixed, .cnt_crc, .cnt_dbl
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int rst_edges = 0;

  // kinds: 0 clean, 1 single repaired, 2 crc bad, 3 double
  int           cur_kind = 0;
  logic [103:0] cur_pay  = '0;

  // reference model state
  bit           pend_v = 0;
  int           pend_kind = 0;
  logic [103:0] pend_pay = '0;
  logic [103:0] e_pay = '0;
  logic         e_upd = 0, e_retx = 0, e_rem = 0;
  logic [CN-1:0] e_cnt [4] = '{default: '0};

  function automatic logic [15:0] ref_crc(input logic [103:0] d);
    logic [15:0] r = 16'hFFFF;
    for (int i = 103; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [127:0] enc(input logic [103:0] pay, input logic [15:0] crcx);
    logic [119:0] d;
    logic [127:0] w = '0;
    logic [6:0]   s = '0;
    int           k = 0;
    d = {ref_crc(pay) ^ crcx, pay};
    for (int p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin w[p] = d[k]; k++; end
    end
    for (int p = 1; p < 128; p++) if (w[p]) s ^= 7'(p);
    for (int i = 0; i < 7; i++) w[1 << i] = s[i];
    w[0] = ^w[127:1];
    return w;
  endfunction

  function automatic logic [103:0] rnd_pay();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rst_edges++;
      pend_v = 0; e_pay = '0; e_upd = 0; e_retx = 0; e_rem = 0;
      for (int i = 0; i < 4; i++) e_cnt[i] = '0;
    end else begin
      e_upd = 0;
      if (pend_v) begin
        if (e_cnt[pend_kind] != CMAX) e_cnt[pend_kind] = e_cnt[pend_kind] + 1'b1;
        if (pend_kind < 2) begin
          e_pay = pend_pay; e_upd = 1; e_retx = 0; e_rem = pend_pay[103];
        end else begin
          e_retx = 1;
        end
      end
      pend_v = in_valid;
      pend_kind = cur_kind;
      pend_pay = cur_pay;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        if (rst_edges >= 1) begin
          chk("R10", "pay_q", 128'(pay_q), '0);
          chk("R10", "flags", {pay_upd, retx_req, remote_err}, '0);
          chk("R10", "counters", {cnt_clean, cnt_fixed, cnt_crc, cnt_dbl}, '0);
          chk("R1", "in_ready in reset", 128'(in_ready), '0);
        end
      end else begin
        chk("R1", "in_ready", 128'(in_ready), 128'd1);
        chk("R6", "pay_q", 128'(pay_q), 128'(e_pay));
        chk("R6", "pay_upd", 128'(pay_upd), 128'(e_upd));
        chk("R7", "retx_req", 128'(retx_req), 128'(e_retx));
        chk("R8", "remote_err", 128'(remote_err), 128'(e_rem));
        chk("R2", "cnt_clean", 128'(cnt_clean), 128'(e_cnt[0]));
        chk("R3", "cnt_fixed", 128'(cnt_fixed), 128'(e_cnt[1]));
        chk("R5", "cnt_crc", 128'(cnt_crc), 128'(e_cnt[2]));
        chk("R4", "cnt_dbl", 128'(cnt_dbl), 128'(e_cnt[3]));
      end
    end
  end

  task automatic send(input int kind, input logic [103:0] pay,
                      input logic [15:0] crcx, input logic [127:0] flips);
    @(negedge clk);
    in_valid = 1'b1;
    in_frame = enc(pay, crcx) ^ flips;
    cur_kind = kind;
    cur_pay  = pay;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_frame = {$urandom, $urandom, $urandom, $urandom};
    cur_kind = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  function automatic logic [127:0] bit_at(input int p);
    return 128'd1 << p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2/R9: long run of clean frames saturates the clean counter
    for (int i = 0; i < 20; i++) send(0, rnd_pay(), '0, '0);
    idle();
    // R3: a single flip at every position, back to back
    for (int p = 0; p < 128; p++) send(1, rnd_pay(), '0, bit_at(p));
    idle(); idle();
    // R4 then R3/R2 in consecutive cycles: reject then accept
    for (int i = 0; i < 10; i++) begin
      int p1 = $urandom % 128;
      int p2 = (p1 + 1 + ($urandom % 127)) % 128;
      send(3, rnd_pay(), '0, bit_at(p1) | bit_at(p2));
      send(0, rnd_pay(), '0, '0);
    end
    // R5: bad CRC, with and without an extra repaired flip
    for (int i = 0; i < 10; i++) begin
      logic [127:0] f = (i % 2 == 1) ? bit_at($urandom % 128) : '0;
      send(2, rnd_pay(), 16'd1 << ($urandom % 16), f);
      if (i % 3 == 0) idle();
    end
    send(1, rnd_pay(), '0, bit_at(0));
    // mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      int k = $urandom % 4;
      logic [103:0] pl = rnd_pay();
      if ($urandom % 4 == 0) idle();
      case (k)
        0: send(0, pl, '0, '0);
        1: send(1, pl, '0, bit_at($urandom % 128));
        2: send(2, pl, 16'd1 << ($urandom % 16),
                ($urandom % 2) ? bit_at($urandom % 128) : '0);
        default: begin
          int p1 = $urandom % 128;
          int p2 = (p1 + 1 + ($urandom % 127)) % 128;
          send(3, pl, '0, bit_at(p1) | bit_at(p2));
        end
      endcase
    end
    repeat (4) idle();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule